// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Code Bank

This block holds the digital codes for four 10-bit DAC channels. Each channel has two registers. The input register holds the code from the most recent serial write to that channel. The output register holds the code that currently drives the converter. An upstream serial front end decodes the DAC-select command byte and then presents each following 16-bit data word on `word` together with a one-cycle `word_vld` strobe. The block decodes each word and updates the registers.

Output registers take their value from the input registers in three ways. A write can update one channel's input register and its output register together. A broadcast word copies all four input registers to the output registers. While the external active-low load pin is held low, it also copies all four, after passing through a two-flop synchroniser. The reset value of every register is chosen by a strap input: all ones when the strap is high, and all zeros when it is low.

Top module: `dac_dbuf_bank`

## Requirements
- R1: The bank has four channels of 10-bit codes. Channel i drives `code_out[10*i+9:10*i]`.
- R2: While `rst_n` is low at a rising clock edge, every input register and every output register is loaded with all ones if `strap_hi` is 1, and with all zeros if it is 0.
- R3: A word is decoded as follows: bits 15..12 are the control field and bits 11..2 are the 10-bit code. Bits 1..0 have no effect.
- R4: A word with control value 0 to 3 writes the code into the input register of channel (control value) only. No output register changes.
- R5: A word with control value 4 to 7 writes the code into both the input and the output register of channel (control value − 4). The new code is visible on `code_out` after the clock edge at which `word_vld` is sampled high.
- R6: A word with control value 8 copies every input register into its output register at that edge.
- R7: Words with control values 9 to 15 change no register.
- R8: `load_n` passes through two synchroniser flops. If `load_n` is low at rising edge k, all input registers are copied to the output registers at edge k+2. The copy repeats on every edge for as long as the synchronised level stays low.
- R9: When a write and an active load act in the same cycle, the write is applied first. The written channel's output register therefore receives the new code.
- R10: While `load_n` is high, a word with control value 0 to 3 leaves `code_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_hi | input | 1 | Selects the reset value: 1 for all ones, 0 for all zeros |
| word_vld | input | 1 | One-cycle strobe marking a valid DAC data word |
| word | input | 16 | DAC data word (control field and code) |
| load_n | input | 1 | Asynchronous active-low load pin |
| code_out | output | 40 | Output-register codes, channel 0 in the least significant bits |

## Verification
The bench builds the block with its default parameters: four channels, 10-bit codes, a 16-bit word and a two-flop synchroniser. With these values every control value from 0 to 15 is distinct, and each one can be driven from the vector table. The two-stage synchroniser makes the load latency short enough to sample the edge before the copy and the edge at which it lands. The bench also resets with the strap at each level, which covers both reset patterns.

// File: rtl/dac_dbuf_bank.sv
module dac_dbuf_bank #(
  parameter int CH     = 4,
  parameter int CODE_W = 10,
  parameter int WORD_W = 16,
  parameter int SYNC_N = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strap_hi,
  input  logic                 word_vld,
  input  logic [WORD_W-1:0]    word,
  input  logic                 load_n,
  output logic [CH*CODE_W-1:0] code_out
);
  localparam int CTL_W = 4;
  localparam int SEL_W = $clog2(CH);
  localparam int PAD_W = WORD_W - CTL_W - CODE_W;
  localparam logic [CTL_W-1:0] CTL_UPD  = CTL_W'(CH);
  localparam logic [CTL_W-1:0] CTL_COPY = CTL_W'(2*CH);

  logic [CTL_W-1:0]  ctl;
  logic [CODE_W-1:0] data;
  logic [SYNC_N-1:0] ld_sync;
  logic              load_act, wr_in, wr_upd, copy_all;
  logic [CODE_W-1:0] in_q  [CH];
  logic [CODE_W-1:0] dac_q [CH];

  assign ctl      = word[WORD_W-1 -: CTL_W];
  assign data     = CODE_W'(word[WORD_W-CTL_W-1:0] >> PAD_W);
  assign load_act = ~ld_sync[SYNC_N-1];
  assign wr_in    = word_vld && (ctl < CTL_COPY);
  assign wr_upd   = word_vld && (ctl >= CTL_UPD) && (ctl < CTL_COPY);
  assign copy_all = word_vld && (ctl == CTL_COPY);

  always_ff @(posedge clk) begin
    if (!rst_n) ld_sync <= '1;
    else        ld_sync <= {ld_sync[SYNC_N-2:0], load_n};
  end

  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic              hit;
    logic [CODE_W-1:0] in_nxt;
    assign hit    = wr_in && (ctl[SEL_W-1:0] == SEL_W'(i));
    assign in_nxt = hit ? data : in_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        in_q[i]  <= {CODE_W{strap_hi}};
        dac_q[i] <= {CODE_W{strap_hi}};
      end else begin
        in_q[i] <= in_nxt;
        if (load_act || copy_all || (hit && wr_upd)) dac_q[i] <= in_nxt;
      end
    end

    assign code_out[i*CODE_W +: CODE_W] = dac_q[i];

    a_r2_strap_reset: assert property (@(posedge clk)
      !rst_n |=> (dac_q[i] == {CODE_W{$past(strap_hi)}}) && (in_q[i] == {CODE_W{$past(strap_hi)}}))
      else $error("R2 reset value");

    a_r4_input_only: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && ctl < CTL_UPD && !load_act) |=> $stable(dac_q[i]))
      else $error("R4 output changed");

    a_r5_write_update: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && ctl == CTL_W'(CH + i)) |=> (dac_q[i] == $past(data)) && (in_q[i] == $past(data)))
      else $error("R5 update");

    a_r6_copy_all: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && ctl == CTL_COPY) |=> dac_q[i] == in_q[i])
      else $error("R6 copy");

    a_r7_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && ctl > CTL_COPY && !load_act) |=> $stable(dac_q[i]) && $stable(in_q[i]))
      else $error("R7 ignored code");

    a_r8_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (load_act && !word_vld) |=> dac_q[i] == in_q[i])
      else $error("R8 load copy");
  end
endmodule

// File: tb/tb_dac_dbuf_bank.sv
module tb_dac_dbuf_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        strap_hi = 0;
  logic        word_vld = 0;
  logic [15:0] word = '0;
  logic        load_n = 1;
  logic [39:0] code_out;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dac_dbuf_bank dut (.clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .word_vld(word_vld),
                     .word(word), .load_n(load_n), .code_out(code_out));

  localparam int NV = 10;
  localparam logic [55:0] VEC [NV] = '{
    {16'h0554, 10'h000, 10'h000, 10'h000, 10'h000},
    {16'h8000, 10'h000, 10'h000, 10'h000, 10'h155},
    {16'h5AA8, 10'h000, 10'h000, 10'h2AA, 10'h155},
    {16'h2FFC, 10'h000, 10'h000, 10'h2AA, 10'h155},
    {16'h9004, 10'h000, 10'h000, 10'h2AA, 10'h155},
    {16'h7200, 10'h080, 10'h000, 10'h2AA, 10'h155},
    {16'h8000, 10'h080, 10'h3FF, 10'h2AA, 10'h155},
    {16'h0007, 10'h080, 10'h3FF, 10'h2AA, 10'h155},
    {16'hFFFF, 10'h080, 10'h3FF, 10'h2AA, 10'h155},
    {16'h8000, 10'h080, 10'h3FF, 10'h2AA, 10'h001}
  };
  localparam string VREQ [NV] = '{"R4", "R6", "R5", "R4", "R7", "R5", "R6", "R3", "R7", "R3"};

  task automatic chk(string req, logic [39:0] act, logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: code_out=%h expected %h", req, act, exp);
    end
  endtask

  task automatic send(logic [15:0] w);
    @(negedge clk); word_vld = 1; word = w;
    @(negedge clk); word_vld = 0; word = '0;
  endtask

  task automatic do_reset(logic s);
    @(negedge clk); rst_n = 0; strap_hi = s;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    do_reset(1'b1);
    chk("R2", code_out, {4{10'h3FF}});
    send(16'h8000);
    chk("R2", code_out, {4{10'h3FF}});
    do_reset(1'b0);
    chk("R2", code_out, 40'h0);

    for (int k = 0; k < NV; k++) begin
      send(VEC[k][55:40]);
      chk(VREQ[k], code_out, VEC[k][39:0]);
    end

    send(16'h0000);
    send(16'h8000);
    chk("R1", code_out, {10'h080, 10'h3FF, 10'h2AA, 10'h000});

    send(16'h048C);
    chk("R10", code_out, {10'h080, 10'h3FF, 10'h2AA, 10'h000});
    load_n = 0;
    @(negedge clk);
    chk("R8", code_out, {10'h080, 10'h3FF, 10'h2AA, 10'h000});
    @(negedge clk);
    chk("R8", code_out, {10'h080, 10'h3FF, 10'h2AA, 10'h000});
    @(negedge clk);
    chk("R8", code_out, {10'h080, 10'h3FF, 10'h2AA, 10'h123});

    send(16'h13C0);
    chk("R9", code_out, {10'h080, 10'h3FF, 10'h0F0, 10'h123});

    @(negedge clk); load_n = 1;
    repeat (3) @(negedge clk);
    send(16'h2044);
    repeat (3) @(negedge clk);
    chk("R10", code_out, {10'h080, 10'h3FF, 10'h0F0, 10'h123});
    send(16'h8000);
    chk("R6", code_out, {10'h080, 10'h011, 10'h0F0, 10'h123});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: finished=0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule